// File: doc/BRIEF.md
# Gain-Ranged Sample Input Converter

This block sits at the entry of a receive datapath and turns a 17-bit sample bus into a 24-bit signed value for later stages. A strobe marks each new sample. In the plain fixed-point setting the bus is taken as one signed 17-bit number and sign-extended. In either floating-point setting, the upper bits of the bus hold a signed mantissa and the lowest bits hold an exponent. Each exponent step raises the mantissa by a factor of two, which is 6 dB. The exponent bits do not appear in the result.

Two floating-point layouts are supported. The narrow-mantissa layout has a 3-bit exponent, and codes beyond three are held at the largest shift. The wide-mantissa layout has a 2-bit exponent. Separately, a complex setting treats the strobed cycle as the in-phase sample and the very next cycle as the quadrature sample. The block issues a single output beat carrying both samples. In real operation the quadrature output is zero.

Top module: `fpin_conv`

## Requirements
- R1: While reset is asserted and after it is released, and before any strobe, `out_vld` is 0 and `out_i` and `out_q` are 0.
- R2: When `cfg_float`=0, a strobed sample produces `out_i` equal to `bus_in[16:0]` read as a two's-complement number and sign-extended to 24 bits.
- R3: When `cfg_float`=1 and `cfg_wide`=0, the mantissa is `bus_in[16:4]` and the exponent code is `bus_in[3:1]`. `bus_in[0]` is ignored. For codes 0 to 3, `out_i` is the sign-extended value of `{bus_in[16:4],4'b0}` shifted left by the code.
- R4: In the narrow-mantissa layout, exponent codes 4 to 7 give the same result as code 3, a left shift of 3.
- R5: When `cfg_float`=1 and `cfg_wide`=1, the mantissa is `bus_in[16:2]` and the exponent code is `bus_in[1:0]`. `out_i` is the sign-extended value of `{bus_in[16:2],2'b0}` shifted left by the code, which runs from 0 to 3.
- R6: When `cfg_complex`=0, each strobe sampled on a rising edge makes `out_vld` high for exactly the following cycle, and `out_q` is 0 in that cycle.
- R7: When `cfg_complex`=1, a strobe captures I. The bus on the next rising edge is captured as Q, whether or not the strobe is high there. `out_vld` rises for one cycle after the Q edge, carrying both values. A strobe on the Q edge does not start a new pair.
- R8: `out_i` and `out_q` keep their values in every cycle where `out_vld` is 0.
- R9: With no strobe and no pending Q capture, `out_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 17 | Sample bus; bit 16 is the sign, bit 0 the extension bit below the normal LSB |
| bus_en | input | 1 | Sample strobe (marks I in complex operation) |
| cfg_float | input | 1 | 0: fixed point, 1: floating point |
| cfg_wide | input | 1 | In floating point: 0 selects 13-bit mantissa with 3-bit exponent, 1 selects 15-bit mantissa with 2-bit exponent |
| cfg_complex | input | 1 | 0: real samples, 1: interleaved I then Q |
| out_i | output | 24 | Converted real or in-phase value |
| out_q | output | 24 | Converted quadrature value, 0 in real operation |
| out_vld | output | 1 | One-cycle pulse per output beat |

## Verification
The hardest case to reach is a strobe that lands on the Q edge of a pair. The block must take that cycle as Q data and must not open a new pair. A mode change that arrives while a Q capture is still pending is equally hard to reach. The stimulus drives the strobe with a high duty cycle in complex operation so that back-to-back strobes occur often. Phases follow one another without idle gaps, so a pending Q can run into a changed format or into real operation. Exponent fields are drawn from dedicated ranges so that the clamped codes and every legal shift each occur many times.

// File: rtl/fpin_pkg.sv
package fpin_pkg;

    typedef enum logic [1:0] {
        FMT_FIXED  = 2'd0,
        FMT_NARROW = 2'd1,
        FMT_WIDE   = 2'd2
    } fmt_e;

    function automatic fmt_e pick_fmt(input logic is_float, input logic is_wide);
        if (!is_float)
            return FMT_FIXED;
        else if (is_wide)
            return FMT_WIDE;
        else
            return FMT_NARROW;
    endfunction

endpackage

// File: rtl/fpin_decode.sv
module fpin_decode
    import fpin_pkg::*;
#(
    parameter int BUS_W       = 17,
    parameter int OUT_W       = 24,
    parameter int NARROW_EW   = 3,
    parameter int WIDE_EW     = 2,
    parameter int MAX_SHIFT   = 3
) (
    input  logic [BUS_W-1:0] bus_i,
    input  fmt_e             fmt_i,
    output logic [OUT_W-1:0] value_o
);

    localparam int SH_W = $clog2(MAX_SHIFT + 1);
    // the narrow layout also discards the extension bit below its exponent
    localparam logic [BUS_W-1:0] KEEP_NARROW =
        ~((BUS_W'(1) << (NARROW_EW + 1)) - BUS_W'(1));
    localparam logic [BUS_W-1:0] KEEP_WIDE =
        ~((BUS_W'(1) << WIDE_EW) - BUS_W'(1));

    logic [NARROW_EW-1:0] code_narrow;
    logic [WIDE_EW-1:0]   code_wide;
    logic [SH_W-1:0]      shift_narrow;
    logic [SH_W-1:0]      shift_wide;
    logic [SH_W-1:0]      shift;
    logic [BUS_W-1:0]     masked;
    logic [OUT_W-1:0]     extended;

    assign code_narrow = bus_i[NARROW_EW:1];
    assign code_wide   = bus_i[WIDE_EW-1:0];

    // clamp only where the code field can exceed the shift limit
    generate
        if ((1 << NARROW_EW) - 1 > MAX_SHIFT) begin : g_clamp_narrow
            assign shift_narrow = (int'(code_narrow) > MAX_SHIFT) ?
                                  SH_W'(MAX_SHIFT) : SH_W'(code_narrow);
        end else begin : g_pass_narrow
            assign shift_narrow = SH_W'(code_narrow);
        end
        if ((1 << WIDE_EW) - 1 > MAX_SHIFT) begin : g_clamp_wide
            assign shift_wide = (int'(code_wide) > MAX_SHIFT) ?
                                SH_W'(MAX_SHIFT) : SH_W'(code_wide);
        end else begin : g_pass_wide
            assign shift_wide = SH_W'(code_wide);
        end
    endgenerate

    always_comb begin
        case (fmt_i)
            FMT_NARROW: begin
                masked = bus_i & KEEP_NARROW;
                shift  = shift_narrow;
            end
            FMT_WIDE: begin
                masked = bus_i & KEEP_WIDE;
                shift  = shift_wide;
            end
            default: begin
                masked = bus_i;
                shift  = '0;
            end
        endcase
        extended = {{(OUT_W - BUS_W){masked[BUS_W-1]}}, masked};
        value_o  = extended << shift;
    end

    // the result width leaves room for the largest shift, so the sign survives
    always_comb begin
        if (!$isunknown(bus_i) && !$isunknown(fmt_i))
            AST_SIGN_KEPT: assert (value_o[OUT_W-1] == bus_i[BUS_W-1]); // R2
    end

endmodule

// File: rtl/fpin_pair.sv
module fpin_pair #(
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             complex_i,
    input  logic [OUT_W-1:0] conv_i,
    output logic [OUT_W-1:0] out_i_o,
    output logic [OUT_W-1:0] out_q_o,
    output logic             out_vld_o
);

    typedef struct packed {
        logic             wait_q;
        logic [OUT_W-1:0] i_hold;
        logic [OUT_W-1:0] out_i;
        logic [OUT_W-1:0] out_q;
        logic             vld;
    } pair_st_t;

    pair_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.wait_q) begin
            // second cycle of a pair: bus is Q, strobe ignored
            st_d.out_i  = st_q.i_hold;
            st_d.out_q  = conv_i;
            st_d.vld    = 1'b1;
            st_d.wait_q = 1'b0;
        end else if (strobe_i) begin
            if (complex_i) begin
                st_d.i_hold = conv_i;
                st_d.wait_q = 1'b1;
            end else begin
                st_d.out_i = conv_i;
                st_d.out_q = '0;
                st_d.vld   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_i_o   = st_q.out_i;
    assign out_q_o   = st_q.out_q;
    assign out_vld_o = st_q.vld;

    AST_REAL_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !complex_i && !st_q.wait_q) |=> (out_vld_o && out_q_o == '0)); // R6

    AST_PAIR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && complex_i && !st_q.wait_q) |=> !out_vld_o); // R7

    AST_PAIR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && complex_i && !st_q.wait_q) |=> ##1 out_vld_o); // R7

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld_o |-> ($stable(out_i_o) && $stable(out_q_o))); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> ($past(strobe_i) || $past(st_q.wait_q))); // R9

endmodule

// File: rtl/fpin_conv.sv
module fpin_conv
    import fpin_pkg::*;
#(
    parameter int BUS_W     = 17,
    parameter int OUT_W     = 24,
    parameter int NARROW_EW = 3,
    parameter int WIDE_EW   = 2,
    parameter int MAX_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             bus_en,
    input  logic             cfg_float,
    input  logic             cfg_wide,
    input  logic             cfg_complex,
    output logic [OUT_W-1:0] out_i,
    output logic [OUT_W-1:0] out_q,
    output logic             out_vld
);

    fmt_e             fmt;
    logic [OUT_W-1:0] conv_val;

    assign fmt = pick_fmt(cfg_float, cfg_wide);

    fpin_decode #(
        .BUS_W     (BUS_W),
        .OUT_W     (OUT_W),
        .NARROW_EW (NARROW_EW),
        .WIDE_EW   (WIDE_EW),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_decode (
        .bus_i   (bus_in),
        .fmt_i   (fmt),
        .value_o (conv_val)
    );

    fpin_pair #(
        .OUT_W (OUT_W)
    ) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (bus_en),
        .complex_i (cfg_complex),
        .conv_i    (conv_val),
        .out_i_o   (out_i),
        .out_q_o   (out_q),
        .out_vld_o (out_vld)
    );

endmodule

// File: tb/fpin_conv_tb.sv
module fpin_conv_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] bus_in = '0;
    logic        bus_en = 1'b0;
    logic        cfg_float = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_complex = 1'b0;
    logic [23:0] out_i, out_q;
    logic        out_vld;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [23:0] exp_i = '0, exp_q = '0;
    logic        exp_vld = 1'b0;
    int          pend[$];

    always #10 clk = ~clk;

    fpin_conv u_dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_en(bus_en),
        .cfg_float(cfg_float), .cfg_wide(cfg_wide), .cfg_complex(cfg_complex),
        .out_i(out_i), .out_q(out_q), .out_vld(out_vld)
    );

    // numeric value from the requirement text, built with integer arithmetic
    function automatic int expect_val(logic [16:0] b, logic fl, logic wd);
        int v;
        int e;
        logic [16:0] m;
        if (!fl) begin
            m = b;
            e = 0;
        end else if (!wd) begin
            m = {b[16:4], 4'b0000};
            e = int'(b[3:1]);
            if (e > 3) e = 3;
        end else begin
            m = {b[16:2], 2'b00};
            e = int'(b[1:0]);
        end
        v = m[16] ? int'(m) - 131072 : int'(m);
        return v * (2 ** e);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_i = '0;
            exp_q = '0;
            exp_vld = 1'b0;
            pend.delete();
        end else begin
            exp_vld = 1'b0;
            if (pend.size() > 0) begin
                exp_i = 24'(pend.pop_front());
                exp_q = 24'(expect_val(bus_in, cfg_float, cfg_wide));
                exp_vld = 1'b1;
            end else if (bus_en) begin
                if (cfg_complex)
                    pend.push_back(expect_val(bus_in, cfg_float, cfg_wide));
                else begin
                    exp_i = 24'(expect_val(bus_in, cfg_float, cfg_wide));
                    exp_q = '0;
                    exp_vld = 1'b1;
                end
            end
        end
    end

    task automatic check_now(string tag);
        checks++;
        if (out_vld !== exp_vld || out_i !== exp_i || out_q !== exp_q) begin
            failures++;
            $display("FAIL %s actual vld=%0b i=%06h q=%06h expected vld=%0b i=%06h q=%06h",
                     tag, out_vld, out_i, out_q, exp_vld, exp_i, exp_q);
        end
    endtask

    // exp_mode: 0 any bus, 1 narrow code 0..3, 2 narrow code 4..7
    task automatic run_phase(string tag, logic fl, logic wd, logic cx,
                             int n, int en_pct, int exp_mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_now(tag);
            cfg_float   = fl;
            cfg_wide    = wd;
            cfg_complex = cx;
            bus_in      = 17'($urandom);
            if (exp_mode == 1) bus_in[3:1] = 3'($urandom_range(0, 3));
            if (exp_mode == 2) bus_in[3:1] = 3'($urandom_range(4, 7));
            bus_en      = ($urandom_range(0, 99) < en_pct);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R1 after release");
        // fixed patterns: extremes of the signed range
        @(negedge clk); bus_in = 17'h10000; bus_en = 1'b1;
        @(negedge clk); check_now("R2 most negative"); bus_in = 17'h0FFFF;
        @(negedge clk); check_now("R2 most positive"); bus_en = 1'b0;
        run_phase("R2 fixed",          0, 0, 0, 300, 60, 0);
        run_phase("R3 narrow float",   1, 0, 0, 300, 60, 1);
        run_phase("R4 narrow clamp",   1, 0, 0, 300, 60, 2);
        run_phase("R5 wide float",     1, 1, 0, 300, 60, 0);
        run_phase("R6 real dense",     1, 1, 0, 200, 100, 0);
        run_phase("R7 complex dense",  1, 0, 1, 400, 80, 0);
        run_phase("R7 complex fixed",  0, 0, 1, 300, 50, 0);
        run_phase("R8 sparse hold",    1, 1, 1, 300, 10, 0);
        run_phase("R6 real after cx",  1, 0, 0, 200, 40, 1);
        run_phase("R9 no strobe",      0, 1, 1, 100, 0, 0);
        @(negedge clk);
        check_now("R9 final idle");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule